// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block produces the digital timing of a data converter that converts on command, running from a master clock. An active-low request input, `start_n`, begins a conversion on its falling edge. Each conversion lasts a fixed number of master clocks. At the end of a conversion the active-low strobe `done_n` falls. In the same cycle the sample word on `sample_in` is captured into the result register. A request that stays low chains conversions back to back. Feeding `done_n` straight back into `start_n` makes the block oscillate with a slightly longer period. A short low pulse gives a single conversion.

The request passes through a two-stage synchroniser and then an edge detector. The `skew_sel` input adds 0 to 2 further cycles of start delay. This models, in a repeatable way, the start uncertainty of a request that is not aligned to the clock. The reset release is sampled on a falling clock edge, so the conversion phase is fixed by reset when the request is held low. Two instances that share a clock and a reset therefore run in lock step.

Top module: `conv_timing_seq`

## Requirements
- R1: While `rst_n` is low, no conversion starts: `done_n` stays 1, `result` is 0 and `result_valid` is 0, even with `start_n` held low.
- R2: With `skew_sel` = 0, if `start_n` falls and is first sampled low at rising edge E, then `done_n` falls at rising edge E+161. From a fall driven just after an edge, this is 162 cycles. Each `skew_sel` step of 1 adds one cycle.
- R3: While `start_n` stays low, `done_n` falls once every 160 cycles.
- R4: When `start_n` is driven by `done_n`, `done_n` falls every 162 + `skew_sel` cycles.
- R5: `skew_sel` values above 2 act as 2. The longest delay from a request fall to a `done_n` fall is therefore 164 cycles.
- R6: With `skew_sel` = 0, suppose `start_n` rises while a conversion runs, N cycles before `done_n` falls (the rise is driven after the edge N cycles before the completion edge). If N is 20 or more, no further conversion follows. If N is 19 or fewer, exactly one more conversion follows.
- R7: `result` takes the value of `sample_in` at the same edge where `done_n` falls, and holds its value at all other times. `result_valid` rises at the first completion.
- R8: After a completion, `done_n` stays low until a new conversion is running. It returns high on the edge after that conversion starts, so in back-to-back mode it is low for exactly one cycle.
- R9: With `start_n` held low and `skew_sel` = 0, `done_n` first falls on the 162nd rising edge after the falling edge that samples the release of `rst_n`. Two instances that share `clk` and `rst_n` produce identical `done_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; its release is sampled on a falling clock edge |
| start_n | input | 1 | Active-low conversion request, may be asynchronous |
| skew_sel | input | SKEW_W (2) | Extra start delay in cycles, 0 to MAX_SKEW |
| sample_in | input | DATA_W (16) | Word captured at the end of a conversion |
| done_n | output | 1 | Active-low completion strobe |
| result | output | DATA_W (16) | Captured conversion word |
| result_valid | output | 1 | Set once the first conversion completes |

## Verification
The bound checker watches four things on every cycle. It confirms that `done_n` and `result_valid` stay quiet during reset. It confirms that `result` changes only on a falling `done_n` and that the result is valid whenever the strobe is low. It also uses a cycle counter to confirm that two completions are never closer than 160 cycles apart.

Some behaviours can only be shown by the bench's scenarios, because they depend on how the request is driven. These are:
- the exact start latency for each skew setting;
- the 162-cycle feedback period;
- the cutoff at exactly 19 versus 20 cycles;
- the conversion phase set by reset;
- lock step between two instances.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

   // Length of the request delay chain: synchroniser stages plus skew taps
   function automatic int req_chain_len(input int stages, input int max_skew);
      return stages + max_skew;
   endfunction

   // Counter value at which the continue decision is committed
   function automatic int commit_point(input int conv, input int guard, input int stages);
      return conv - guard + stages - 1;
   endfunction

endpackage

// File: rtl/conv_rst_sampler.sv
`timescale 1ns/1ps
module conv_rst_sampler #(
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   output logic rel_q
);

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) rel_q <= 1'b0;
            else        rel_q <= 1'b1;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rel_q <= 1'b0;
            else        rel_q <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/conv_req_sync.sv
`timescale 1ns/1ps
module conv_req_sync
   import conv_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_SKEW    = 2,
   localparam int SKEW_W     = $clog2(MAX_SKEW + 1),
   localparam int CHAIN_LEN  = req_chain_len(SYNC_STAGES, MAX_SKEW),
   localparam int TAP_BASE   = SYNC_STAGES - 2
) (
   input  logic              clk,
   input  logic              rel_q,
   input  logic              start_n,
   input  logic [SKEW_W-1:0] skew_sel,
   output logic              req_fall,
   output logic              req_low
);

   logic [CHAIN_LEN-1:0] chain_q;
   logic [SKEW_W-1:0]    skew_eff;
   logic                 tap_cur;
   logic                 tap_old;

   // first stage samples the raw request
   always_ff @(posedge clk) begin
      if (!rel_q) chain_q[0] <= 1'b1;
      else        chain_q[0] <= start_n;
   end

   // remaining synchroniser and skew stages
   generate
      for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rel_q) chain_q[g] <= 1'b1;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   assign skew_eff = (skew_sel > SKEW_W'(MAX_SKEW)) ? SKEW_W'(MAX_SKEW) : skew_sel;

   always_comb begin
      tap_cur = chain_q[TAP_BASE];
      tap_old = chain_q[TAP_BASE+1];
      for (int k = 0; k <= MAX_SKEW; k++) begin
         if (skew_eff == SKEW_W'(k)) begin
            tap_cur = chain_q[TAP_BASE+k];
            tap_old = chain_q[TAP_BASE+k+1];
         end
      end
   end

   assign req_fall = tap_old & ~tap_cur;
   assign req_low  = ~tap_cur;

endmodule

// File: rtl/conv_seq_ctrl.sv
`timescale 1ns/1ps
module conv_seq_ctrl
   import conv_seq_pkg::*;
#(
   parameter int CONV_CYCLES  = 160,
   parameter int GUARD_CYCLES = 20,
   parameter int SYNC_STAGES  = 2,
   localparam int CNT_W       = $clog2(CONV_CYCLES),
   localparam int LAST_CNT    = CONV_CYCLES - 1,
   localparam int COMMIT_CNT  = commit_point(CONV_CYCLES, GUARD_CYCLES, SYNC_STAGES)
) (
   input  logic clk,
   input  logic rel_q,
   input  logic req_fall,
   input  logic req_low,
   output logic done_n,
   output logic load
);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             keep_q;
   logic             at_last;
   logic             at_commit;

   assign at_last   = (state_q == SEQ_BUSY) && (cnt_q == CNT_W'(LAST_CNT));
   assign at_commit = (state_q == SEQ_BUSY) && (cnt_q == CNT_W'(COMMIT_CNT));
   assign load      = at_last;

   always_ff @(posedge clk) begin
      if (!rel_q) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         keep_q  <= 1'b0;
         done_n  <= 1'b1;
      end else if (at_last) begin
         // completion: strobe low, optionally chain the next conversion
         done_n <= 1'b0;
         keep_q <= 1'b0;
         cnt_q  <= '0;
         if (keep_q) state_q <= SEQ_BUSY;
         else        state_q <= SEQ_IDLE;
      end else if (state_q == SEQ_BUSY) begin
         cnt_q  <= cnt_q + 1'b1;
         done_n <= 1'b1;
         if (at_commit) keep_q <= req_low;
      end else if (req_fall) begin
         state_q <= SEQ_BUSY;
         cnt_q   <= '0;
      end
   end

endmodule

// File: rtl/conv_result_reg.sv
`timescale 1ns/1ps
module conv_result_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rel_q,
   input  logic              load,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] result,
   output logic              result_valid
);

   always_ff @(posedge clk) begin
      if (!rel_q) begin
         result       <= '0;
         result_valid <= 1'b0;
      end else if (load) begin
         result       <= sample_in;
         result_valid <= 1'b1;
      end
   end

endmodule

// File: rtl/conv_timing_seq.sv
`timescale 1ns/1ps
module conv_timing_seq #(
   parameter int DATA_W       = 16,
   parameter int CONV_CYCLES  = 160,
   parameter int GUARD_CYCLES = 20,
   parameter int SYNC_STAGES  = 2,
   parameter int MAX_SKEW     = 2,
   parameter bit RST_ON_FALL  = 1'b1,
   localparam int SKEW_W      = $clog2(MAX_SKEW + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic [SKEW_W-1:0] skew_sel,
   input  logic [DATA_W-1:0] sample_in,
   output logic              done_n,
   output logic [DATA_W-1:0] result,
   output logic              result_valid
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("conv_timing_seq: DATA_W must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("conv_timing_seq: SYNC_STAGES must be at least 2");
      end
      if (MAX_SKEW < 1) begin : g_bad_skew
         $error("conv_timing_seq: MAX_SKEW must be at least 1");
      end
      if (GUARD_CYCLES < SYNC_STAGES || CONV_CYCLES <= GUARD_CYCLES + 1) begin : g_bad_guard
         $error("conv_timing_seq: guard window must fit inside one conversion");
      end
   endgenerate

   logic rel_q;
   logic req_fall;
   logic req_low;
   logic load;

   conv_rst_sampler #(
      .FALL_EDGE (RST_ON_FALL)
   ) u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .rel_q (rel_q)
   );

   conv_req_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .MAX_SKEW    (MAX_SKEW)
   ) u_sync (
      .clk      (clk),
      .rel_q    (rel_q),
      .start_n  (start_n),
      .skew_sel (skew_sel),
      .req_fall (req_fall),
      .req_low  (req_low)
   );

   conv_seq_ctrl #(
      .CONV_CYCLES  (CONV_CYCLES),
      .GUARD_CYCLES (GUARD_CYCLES),
      .SYNC_STAGES  (SYNC_STAGES)
   ) u_ctrl (
      .clk      (clk),
      .rel_q    (rel_q),
      .req_fall (req_fall),
      .req_low  (req_low),
      .done_n   (done_n),
      .load     (load)
   );

   conv_result_reg #(
      .DATA_W (DATA_W)
   ) u_res (
      .clk          (clk),
      .rel_q        (rel_q),
      .load         (load),
      .sample_in    (sample_in),
      .result       (result),
      .result_valid (result_valid)
   );

endmodule

// File: rtl/conv_timing_seq_chk.sv
`timescale 1ns/1ps
module conv_timing_seq_chk #(
   parameter int DATA_W      = 16,
   parameter int CONV_CYCLES = 160,
   localparam int GAP_W      = $clog2(CONV_CYCLES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_n,
   input logic [DATA_W-1:0] result,
   input logic              result_valid
);

   logic [GAP_W-1:0] gap_q;
   logic             done_d;

   // cycles since the previous completion strobe, saturating
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= GAP_W'(CONV_CYCLES);
         done_d <= 1'b1;
      end else begin
         done_d <= done_n;
         if (done_d && !done_n)              gap_q <= GAP_W'(1);
         else if (gap_q < GAP_W'(CONV_CYCLES)) gap_q <= gap_q + 1'b1;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (done_n && !result_valid));

   assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_n) |-> (gap_q >= GAP_W'(CONV_CYCLES)));

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(done_n) |-> $stable(result));

   assert_valid_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_n |-> result_valid);

endmodule

bind conv_timing_seq conv_timing_seq_chk #(
   .DATA_W      (DATA_W),
   .CONV_CYCLES (CONV_CYCLES)
) u_conv_timing_seq_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .done_n       (done_n),
   .result       (result),
   .result_valid (result_valid)
);

// File: tb/conv_timing_seq_bench.sv
`timescale 1ns/1ps
module conv_timing_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int CONV       = 160;
   localparam int GUARD      = 20;
   localparam int MAX_SKEW   = 2;
   localparam int SKEW_W     = $clog2(MAX_SKEW + 1);
   localparam int WATCHDOG   = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_drv = 1'b0;
   logic              tie_en = 1'b0;
   logic [SKEW_W-1:0] skew = '0;
   logic [DATA_W-1:0] sample = '0;
   logic              start_a;
   logic              done_a, done_b;
   logic [DATA_W-1:0] res_a, res_b;
   logic              val_a, val_b;
   logic              cmp_en = 1'b0;
   int                mis = 0;
   int                checks = 0;
   int                errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign start_a = tie_en ? done_a : start_drv;

   conv_timing_seq u_conv_timing_seq (
      .clk(clk), .rst_n(rst_n), .start_n(start_a), .skew_sel(skew),
      .sample_in(sample), .done_n(done_a), .result(res_a), .result_valid(val_a));

   conv_timing_seq u_conv_timing_seq_b (
      .clk(clk), .rst_n(rst_n), .start_n(start_drv), .skew_sel(skew),
      .sample_in(sample), .done_n(done_b), .result(res_b), .result_valid(val_b));

   always @(negedge clk) if (cmp_en && (done_a !== done_b)) mis++;

   function automatic int eff_skew(input int k);
      return (k > MAX_SKEW) ? MAX_SKEW : k;
   endfunction

   function automatic int exp_latency(input int k);
      return CONV + 2 + eff_skew(k);
   endfunction

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_fall(input int limit, output int n, output bit seen);
      logic pv;
      pv = done_a; n = 0; seen = 1'b0;
      while (n < limit && !seen) begin
         step();
         n++;
         if (pv && !done_a) seen = 1'b1;
         pv = done_a;
      end
   endtask

   // called right after a completion was observed with start held low
   task automatic cutoff(input int nb);
      int n; bit seen; logic [DATA_W-1:0] w;
      repeat (CONV - nb) step();
      start_drv = 1'b1;
      wait_fall(400, n, seen);
      check(seen && n == nb, "R6 running conversion ends", n, nb);
      if (nb < GUARD) begin
         wait_fall(400, n, seen);
         check(seen && n == CONV, "R6 one more conversion", n, CONV);
      end
      w = res_a;
      wait_fall(400, n, seen);
      check(!seen && !done_a, "R6 no further conversion", int'(seen), 0);
      check(res_a == w, "R7 result held while idle", res_a, w);
   endtask

   task automatic run_single(input int k, input int pw, input int dly);
      int n; bit seen; logic pv; logic [DATA_W-1:0] w;
      skew = SKEW_W'(k);
      repeat (8) step();
      w = DATA_W'($urandom());
      sample = w;
      #(dly);
      start_drv = 1'b0;
      pv = done_a; n = 0; seen = 1'b0;
      while (n < 400 && !seen) begin
         step();
         n++;
         if (n == pw) start_drv = 1'b1;
         if (pv && !done_a) seen = 1'b1;
         pv = done_a;
      end
      check(seen && n == exp_latency(k), (k > MAX_SKEW) ? "R5 clamped skew latency" : "R2 start latency",
            n, exp_latency(k));
      check(res_a == w, "R7 word captured", res_a, w);
      wait_fall(300, n, seen);
      check(!seen && !done_a, "R6 single shot stops, R8 strobe stays low", int'(seen), 0);
   endtask

   task automatic run_tied(input int k);
      int n; bit seen; logic [DATA_W-1:0] w;
      tie_en = 1'b0; start_drv = 1'b1; skew = SKEW_W'(k);
      repeat (8) step();
      tie_en = 1'b1;
      wait_fall(400, n, seen);
      check(seen && n == exp_latency(k), "R4 loop entry", n, exp_latency(k));
      for (int p = 0; p < 3; p++) begin
         w = DATA_W'($urandom());
         sample = w;
         wait_fall(400, n, seen);
         check(seen && n == CONV + 2 + k, "R4 feedback period", n, CONV + 2 + k);
         check(res_a == w, "R7 word in feedback mode", res_a, w);
      end
      tie_en = 1'b0; start_drv = 1'b1;
      repeat (400) step();
   endtask

   initial begin
      int n; bit seen; int lows; logic [DATA_W-1:0] w;
      void'($urandom(32'd4242));
      // R1: long reset with the request held low
      lows = 0;
      repeat (300) begin
         step();
         if (!done_a || !done_b) lows++;
      end
      check(lows == 0, "R1 no strobe during reset", lows, 0);
      check(res_a == 0 && !val_a, "R1 reset result state", res_a, 0);

      // R9: reset release sets the phase
      w = DATA_W'($urandom());
      sample = w;
      cmp_en = 1'b1;
      rst_n = 1'b1;
      wait_fall(400, n, seen);
      check(seen && n == 162, "R9 first completion after release", n, 162);
      check(!done_b, "R9 second instance aligned", int'(done_b), 0);
      check(res_a == w && val_a, "R7 first word and valid", res_a, w);

      // R3: back-to-back conversions
      for (int i = 0; i < 3; i++) begin
         w = DATA_W'($urandom());
         sample = w;
         wait_fall(400, n, seen);
         check(seen && n == CONV, "R3 continuous period", n, CONV);
         check(res_a == w, "R7 word per conversion", res_a, w);
      end
      step();
      check(done_a, "R8 strobe low one cycle in continuous mode", int'(done_a), 1);
      wait_fall(400, n, seen);
      check(seen && n == CONV - 1, "R3 period after one cycle", n, CONV - 1);

      // R6: rise 19 cycles before the strobe keeps one more conversion
      cutoff(19);

      // R2/R5: directed single shots for every skew, including a clamped one
      for (int k = 0; k <= 3; k++) run_single(k, 3 + k, k);

      // constrained random single shots
      for (int i = 0; i < 6; i++)
         run_single(int'($urandom_range(0, 3)), int'($urandom_range(1, 100)), int'($urandom_range(0, 6)));

      // R6: directed 20-cycle cutoff, then random cutoffs around the boundary
      for (int i = 0; i < 4; i++) begin
         int nb;
         nb = (i == 0) ? GUARD : int'($urandom_range(12, 28));
         skew = '0;
         repeat (8) step();
         start_drv = 1'b0;
         wait_fall(400, n, seen);
         check(seen && n == exp_latency(0), "R2 restart latency", n, exp_latency(0));
         cutoff(nb);
      end

      cmp_en = 1'b0;
      check(mis == 0, "R9 instances in lock step", mis, 0);

      // R4: feedback loop for every skew
      for (int k = 0; k <= MAX_SKEW; k++) run_tied(k);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule